// File: doc/BRIEF.md
# Four-Direction Parity Matrix Codec

This block protects a 64-bit data word with a two-dimensional parity code. The word is treated as an 8x8 grid of cells. Parity is taken along every row, every column, every slash diagonal (cells whose row plus column is constant) and every backslash diagonal (cells whose row minus column is constant). A combinational encoder turns a data word into a 114-bit codeword. The 114 bits are the 64 data bits, 46 line parities, and one summary parity for each of the four line families.

A registered decoder takes a received 114-bit word together with a valid strobe. One clock later it presents the repaired data and exactly one of three outcome flags: clean, fixed or bad. Each line is checked against its recomputed parity, and data bits are located where failing lines of different directions cross. A flip mask is accepted only if its own line signature explains every failing line exactly. If that cannot be done, the decoder tries a parity-only explanation. When neither succeeds, the word is reported as bad and the data is left unchanged.

Top module: `pmx_codec`

## Requirements
- R1: `encWord[63:0]` equals `encData`, where data bit `r*8+c` lies at row r and column c. Bit `64+r` is the XOR of row r and bit `72+c` is the XOR of column c.
- R2: Bit `80+k` is the XOR of every cell with r+c = k (k = 0..14). Bit `95+k` is the XOR of every cell with r-c+7 = k (k = 0..14).
- R3: Bits 110, 111, 112 and 113 are the XOR of bits 71..64, 79..72, 94..80 and 109..95 respectively.
- R4: `decValidOut` is high exactly one cycle after each cycle in which `decValidIn` is high. In cycles without it, `decData` and the flags keep their previous values.
- R5: A word that is an exact codeword gives `decClean` with `decData` equal to its data bits.
- R6: A single flipped data bit, at any cell, is restored and `decFixed` is raised.
- R7: Any two flipped data bits are restored and `decFixed` is raised. This includes two bits that share a row, a column or a diagonal.
- R8: Three flipped data bits are restored with `decFixed` when they meet two conditions. First, no two of them share a line. Second, no other cell lies on flagged lines of all four directions. Cells 1, 31 and 51 form such a set.
- R9: One to three flipped bits confined to positions 64..113 leave `decData` equal to the original data and raise `decFixed`.
- R10: A received word that has no consistent explanation raises `decBad` and passes its data bits through unchanged. Examples are data bit 27 flipped with bit 67, and data bit 0 flipped with bit 110.
- R11: Every output with `decValidOut` high carries exactly one of `decClean`, `decFixed`, `decBad`.
- R12: While `rstN` is low, `decValidOut`, `decData` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| encData | input | 64 | Data word to encode |
| encWord | output | 114 | Codeword, combinational from encData |
| decValidIn | input | 1 | decWord carries a word to decode this cycle |
| decWord | input | 114 | Received codeword |
| decValidOut | output | 1 | Decode result present |
| decData | output | 64 | Repaired data |
| decClean | output | 1 | No error seen |
| decFixed | output | 1 | Errors found and resolved |
| decBad | output | 1 | Errors found, not resolvable |

## Verification
The encoder has no register, so its codeword is compared a short settle delay after `encData` changes, within the same cycle. Every decode result is due on the first rising edge after the cycle in which its valid input was held. The bench stamps each expectation with the cycle count at which the input was driven. At each falling edge it compares outputs only against the entry stamped one cycle earlier. In every other cycle it demands that valid stays low and that data and flags hold their previous values, so both a late and an early result are caught.

// File: rtl/pmx_pkg.sv
`timescale 1ns/1ps
package pmx_pkg;
  // strobes from the decode control to the decode datapath
  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic useQuad;    // apply the four-line intersection mask
    logic useTriple;  // apply the three-of-four line mask
    logic markClean;
    logic markFixed;
    logic markBad;
  } decStrobe_t;
endpackage

// File: rtl/pmx_lines.sv
`timescale 1ns/1ps
// Parity of every row, column and diagonal of a square cell grid.
module pmx_lines #(
  parameter int SIDE = 8,
  localparam int CELLS = SIDE * SIDE,
  localparam int DIAG = 2 * SIDE - 1
) (
  input  logic [CELLS-1:0] cells,
  output logic [SIDE-1:0]  rowPar,
  output logic [SIDE-1:0]  colPar,
  output logic [DIAG-1:0]  slashPar,
  output logic [DIAG-1:0]  backPar
);
  always_comb begin
    rowPar   = '0;
    colPar   = '0;
    slashPar = '0;
    backPar  = '0;
    for (int r = 0; r < SIDE; r++) begin
      for (int c = 0; c < SIDE; c++) begin
        rowPar[r]              ^= cells[r*SIDE+c];
        colPar[c]              ^= cells[r*SIDE+c];
        slashPar[r+c]          ^= cells[r*SIDE+c];
        backPar[r-c+SIDE-1]    ^= cells[r*SIDE+c];
      end
    end
  end
endmodule

// File: rtl/pmx_encoder.sv
`timescale 1ns/1ps
module pmx_encoder #(
  parameter int SIDE = 8,
  localparam int DATA_W = SIDE * SIDE,
  localparam int DIAG = 2 * SIDE - 1,
  localparam int CW_W = DATA_W + 2 * SIDE + 2 * DIAG + 4
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   word
);
  logic [SIDE-1:0] rowP, colP;
  logic [DIAG-1:0] slP, bkP;

  pmx_lines #(.SIDE(SIDE)) lines_i (
    .cells(data), .rowPar(rowP), .colPar(colP), .slashPar(slP), .backPar(bkP)
  );

  // field order low to high: data, rows, columns, slash, backslash, family parities
  assign word = {^bkP, ^slP, ^colP, ^rowP, bkP, slP, colP, rowP, data};
endmodule

// File: rtl/pmx_dec_datapath.sv
`timescale 1ns/1ps
module pmx_dec_datapath
  import pmx_pkg::*;
#(
  parameter int SIDE = 8,
  localparam int DATA_W = SIDE * SIDE,
  localparam int DIAG = 2 * SIDE - 1,
  localparam int LINES = 2 * SIDE + 2 * DIAG,
  localparam int CW_W = DATA_W + LINES + 4,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int PE_W = $clog2(LINES + 5)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW_W-1:0]   rxWord,
  input  decStrobe_t        strobe,
  output logic              lineZero,
  output logic              setZero,
  output logic [CNT_W-1:0]  quadCount,
  output logic [CNT_W-1:0]  tripleCount,
  output logic              quadResZero,
  output logic              tripleResZero,
  output logic [PE_W-1:0]   parityErrs,
  output logic              validQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              cleanQ,
  output logic              fixedQ,
  output logic              badQ
);
  localparam int ROW_OFS = DATA_W;
  localparam int COL_OFS = ROW_OFS + SIDE;
  localparam int SL_OFS  = COL_OFS + SIDE;
  localparam int BK_OFS  = SL_OFS + DIAG;
  localparam int SET_OFS = BK_OFS + DIAG;

  logic [DATA_W-1:0] rxData;
  logic [SIDE-1:0]   rxRow, rxCol, calcRow, calcCol, synRow, synCol;
  logic [DIAG-1:0]   rxSl, rxBk, calcSl, calcBk, synSl, synBk;
  logic [3:0]        rxSet, setSyn;

  assign rxData = rxWord[DATA_W-1:0];
  assign rxRow  = rxWord[COL_OFS-1:ROW_OFS];
  assign rxCol  = rxWord[SL_OFS-1:COL_OFS];
  assign rxSl   = rxWord[BK_OFS-1:SL_OFS];
  assign rxBk   = rxWord[SET_OFS-1:BK_OFS];
  assign rxSet  = rxWord[CW_W-1:SET_OFS];

  pmx_lines #(.SIDE(SIDE)) recalc_i (
    .cells(rxData), .rowPar(calcRow), .colPar(calcCol), .slashPar(calcSl), .backPar(calcBk)
  );

  assign synRow = calcRow ^ rxRow;
  assign synCol = calcCol ^ rxCol;
  assign synSl  = calcSl ^ rxSl;
  assign synBk  = calcBk ^ rxBk;
  assign setSyn = {^rxBk, ^rxSl, ^rxCol, ^rxRow} ^ rxSet;

  assign lineZero = (synRow == '0) && (synCol == '0) && (synSl == '0) && (synBk == '0);
  assign setZero  = (setSyn == '0);

  // candidate cells: all four lines failing, or at least three of them
  logic [DATA_W-1:0] quadMask, tripleMask;
  always_comb begin
    for (int r = 0; r < SIDE; r++) begin
      for (int c = 0; c < SIDE; c++) begin
        int hits;
        hits = int'(synRow[r]) + int'(synCol[c]) + int'(synSl[r+c]) + int'(synBk[r-c+SIDE-1]);
        quadMask[r*SIDE+c]   = (hits == 4);
        tripleMask[r*SIDE+c] = (hits >= 3);
      end
    end
  end

  always_comb begin
    quadCount   = '0;
    tripleCount = '0;
    for (int i = 0; i < DATA_W; i++) begin
      quadCount   = quadCount + CNT_W'(quadMask[i]);
      tripleCount = tripleCount + CNT_W'(tripleMask[i]);
    end
  end

  // residual test: a mask is accepted only if its line signature equals the syndromes
  logic [DATA_W-1:0] maskSel [2];
  logic [1:0]        resZero;
  assign maskSel[0] = quadMask;
  assign maskSel[1] = tripleMask;

  for (genvar g = 0; g < 2; g++) begin : gRes
    logic [SIDE-1:0] mRow, mCol;
    logic [DIAG-1:0] mSl, mBk;
    pmx_lines #(.SIDE(SIDE)) sig_i (
      .cells(maskSel[g]), .rowPar(mRow), .colPar(mCol), .slashPar(mSl), .backPar(mBk)
    );
    assign resZero[g] = (mRow == synRow) && (mCol == synCol) && (mSl == synSl) && (mBk == synBk);
  end

  assign quadResZero   = resZero[0];
  assign tripleResZero = resZero[1];

  // fewest check-bit flips that explain the syndromes with no data error
  always_comb begin
    parityErrs = '0;
    for (int i = 0; i < SIDE; i++) begin
      parityErrs = parityErrs + PE_W'(synRow[i]) + PE_W'(synCol[i]);
    end
    for (int i = 0; i < DIAG; i++) begin
      parityErrs = parityErrs + PE_W'(synSl[i]) + PE_W'(synBk[i]);
    end
    parityErrs = parityErrs + PE_W'(setSyn[0] ^ (^synRow)) + PE_W'(setSyn[1] ^ (^synCol))
                            + PE_W'(setSyn[2] ^ (^synSl)) + PE_W'(setSyn[3] ^ (^synBk));
  end

  logic [DATA_W-1:0] flipMask;
  always_comb begin
    flipMask = '0;
    if (strobe.useQuad) flipMask = quadMask;
    else if (strobe.useTriple) flipMask = tripleMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      dataQ  <= '0;
      cleanQ <= 1'b0;
      fixedQ <= 1'b0;
      badQ   <= 1'b0;
    end else begin
      validQ <= strobe.load;
      if (strobe.load) begin
        dataQ  <= rxData ^ flipMask;
        cleanQ <= strobe.markClean;
        fixedQ <= strobe.markFixed;
        badQ   <= strobe.markBad;
      end
    end
  end
endmodule

// File: rtl/pmx_dec_control.sv
`timescale 1ns/1ps
module pmx_dec_control
  import pmx_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int PE_W = 6
) (
  input  logic             validIn,
  input  logic             lineZero,
  input  logic             setZero,
  input  logic [CNT_W-1:0] quadCount,
  input  logic [CNT_W-1:0] tripleCount,
  input  logic             quadResZero,
  input  logic             tripleResZero,
  input  logic [PE_W-1:0]  parityErrs,
  output decStrobe_t       strobe
);
  localparam int MAX_FIX = 3;

  logic quadOk, tripleOk, parityOk;
  assign quadOk   = (quadCount != '0) && (quadCount <= CNT_W'(MAX_FIX)) && quadResZero && setZero;
  assign tripleOk = (tripleCount != '0) && (tripleCount <= CNT_W'(MAX_FIX)) && tripleResZero && setZero;
  assign parityOk = (quadCount == '0) && (parityErrs != '0) && (parityErrs <= PE_W'(MAX_FIX));

  always_comb begin
    strobe = '0;
    strobe.load = validIn;
    if (lineZero && setZero) begin
      strobe.markClean = 1'b1;
    end else if (quadOk) begin
      strobe.useQuad   = 1'b1;
      strobe.markFixed = 1'b1;
    end else if (tripleOk) begin
      strobe.useTriple = 1'b1;
      strobe.markFixed = 1'b1;
    end else if (parityOk) begin
      strobe.markFixed = 1'b1;
    end else begin
      strobe.markBad = 1'b1;
    end
  end
endmodule

// File: rtl/pmx_codec.sv
`timescale 1ns/1ps
module pmx_codec
  import pmx_pkg::*;
#(
  parameter int SIDE = 8,
  localparam int DATA_W = SIDE * SIDE,
  localparam int DIAG = 2 * SIDE - 1,
  localparam int LINES = 2 * SIDE + 2 * DIAG,
  localparam int CW_W = DATA_W + LINES + 4,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int PE_W = $clog2(LINES + 5)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [CW_W-1:0]   encWord,
  input  logic              decValidIn,
  input  logic [CW_W-1:0]   decWord,
  output logic              decValidOut,
  output logic [DATA_W-1:0] decData,
  output logic              decClean,
  output logic              decFixed,
  output logic              decBad
);
  decStrobe_t       strobe;
  logic             lineZero, setZero, quadResZero, tripleResZero;
  logic [CNT_W-1:0] quadCount, tripleCount;
  logic [PE_W-1:0]  parityErrs;

  pmx_encoder #(.SIDE(SIDE)) enc_i (.data(encData), .word(encWord));

  pmx_dec_datapath #(.SIDE(SIDE)) dp_i (
    .clk(clk), .rstN(rstN), .rxWord(decWord), .strobe(strobe),
    .lineZero(lineZero), .setZero(setZero),
    .quadCount(quadCount), .tripleCount(tripleCount),
    .quadResZero(quadResZero), .tripleResZero(tripleResZero),
    .parityErrs(parityErrs),
    .validQ(decValidOut), .dataQ(decData),
    .cleanQ(decClean), .fixedQ(decFixed), .badQ(decBad)
  );

  pmx_dec_control #(.CNT_W(CNT_W), .PE_W(PE_W)) ctl_i (
    .validIn(decValidIn), .lineZero(lineZero), .setZero(setZero),
    .quadCount(quadCount), .tripleCount(tripleCount),
    .quadResZero(quadResZero), .tripleResZero(tripleResZero),
    .parityErrs(parityErrs), .strobe(strobe)
  );
endmodule

// File: rtl/pmx_codec_chk.sv
`timescale 1ns/1ps
module pmx_codec_chk #(
  parameter int SIDE = 8,
  localparam int DATA_W = SIDE * SIDE
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] encData,
  input logic [DATA_W-1:0] encDataField,
  input logic              decValidIn,
  input logic [DATA_W-1:0] rxDataIn,
  input logic              decValidOut,
  input logic [DATA_W-1:0] decData,
  input logic              decClean,
  input logic              decFixed,
  input logic              decBad
);
  // R1
  enc_systematic_chk: assert property (@(posedge clk) disable iff (!rstN)
    encDataField == encData);

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValidIn |=> decValidOut);

  // R4
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValidIn |=> !decValidOut);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValidIn |=> ($stable(decData) && $stable(decClean) && $stable(decFixed) && $stable(decBad)));

  // R11
  one_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValidOut |-> ($countones({decClean, decFixed, decBad}) == 1));

  // R5
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValidIn ##1 decClean) |-> (decData == $past(rxDataIn)));

  // R10
  bad_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValidIn ##1 decBad) |-> (decData == $past(rxDataIn)));
endmodule

bind pmx_codec pmx_codec_chk #(.SIDE(SIDE)) chk_i (
  .clk(clk), .rstN(rstN), .encData(encData), .encDataField(encWord[DATA_W-1:0]),
  .decValidIn(decValidIn), .rxDataIn(decWord[DATA_W-1:0]),
  .decValidOut(decValidOut), .decData(decData),
  .decClean(decClean), .decFixed(decFixed), .decBad(decBad)
);

// File: tb/pmx_codec_tb_top.sv
`timescale 1ns/1ps
module pmx_codec_tb_top;
  localparam int DW = 64;
  localparam int CW = 114;
  localparam logic [2:0] F_CLEAN = 3'b100;
  localparam logic [2:0] F_FIXED = 3'b010;
  localparam logic [2:0] F_BAD   = 3'b001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] encData = '0;
  logic [CW-1:0] encWord;
  logic decValidIn = 1'b0;
  logic [CW-1:0] decWord = '0;
  logic decValidOut;
  logic [DW-1:0] decData;
  logic decClean, decFixed, decBad;

  always #2.5 clk = ~clk;

  pmx_codec dut_i (
    .clk(clk), .rstN(rstN), .encData(encData), .encWord(encWord),
    .decValidIn(decValidIn), .decWord(decWord), .decValidOut(decValidOut),
    .decData(decData), .decClean(decClean), .decFixed(decFixed), .decBad(decBad)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    longint stamp;
    logic [DW-1:0] data;
    logic [2:0] flags;
    string req;
  } exp_t;
  exp_t expQ[$];

  logic [DW-1:0] lastData = '0;
  logic [2:0] lastFlags = 3'b000;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural encoder built from the field positions in R1..R3
  function automatic logic [CW-1:0] refEncode(input logic [DW-1:0] d);
    logic [CW-1:0] w;
    w = '0;
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        w[r*8+c] = d[r*8+c];
        w[64+r] ^= d[r*8+c];
        w[72+c] ^= d[r*8+c];
        w[80+r+c] ^= d[r*8+c];
        w[95+r-c+7] ^= d[r*8+c];
      end
    end
    w[110] = ^w[71:64];
    w[111] = ^w[79:72];
    w[112] = ^w[94:80];
    w[113] = ^w[109:95];
    return w;
  endfunction

  function automatic logic [CW-1:0] flip3(input logic [CW-1:0] w, input int a, input int b, input int c);
    logic [CW-1:0] x;
    x = w;
    if (a >= 0) x[a] = ~x[a];
    if (b >= 0) x[b] = ~x[b];
    if (c >= 0) x[c] = ~x[c];
    return x;
  endfunction

  task automatic checkEnc(input logic [DW-1:0] d);
    logic [CW-1:0] e;
    encData = d;
    #1;
    e = refEncode(d);
    check(encWord[79:0] == e[79:0], "R1", "data/row/column fields", CW'(encWord[79:0]), CW'(e[79:0]));
    check(encWord[109:80] == e[109:80], "R2", "diagonal fields", CW'(encWord[109:80]), CW'(e[109:80]));
    check(encWord[113:110] == e[113:110], "R3", "family parities", CW'(encWord[113:110]), CW'(e[113:110]));
  endtask

  task automatic sendWord(input logic [CW-1:0] w, input logic [DW-1:0] expD,
                          input logic [2:0] expF, input string req);
    exp_t item;
    decWord = w;
    decValidIn = 1'b1;
    item.stamp = cyc;
    item.data = expD;
    item.flags = expF;
    item.req = req;
    expQ.push_back(item);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    decValidIn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // reference comparison every cycle, at the falling edge
  always @(negedge clk) begin
    if (monOn) begin
      logic [2:0] flags;
      flags = {decClean, decFixed, decBad};
      if (expQ.size() > 0 && expQ[0].stamp == cyc - 1) begin
        exp_t e;
        e = expQ.pop_front();
        check(decValidOut == 1'b1, "R4", "valid one cycle after input", CW'(decValidOut), CW'(1));
        check(decData == e.data, e.req, "decoded data", CW'(decData), CW'(e.data));
        check(flags == e.flags, e.req, "outcome flags", CW'(flags), CW'(e.flags));
        check($countones(flags) == 1, "R11", "single flag", CW'(flags), CW'(e.flags));
        lastData = decData;
        lastFlags = flags;
      end else begin
        check(decValidOut == 1'b0, "R4", "no valid without input", CW'(decValidOut), CW'(0));
        check(decData == lastData && flags == lastFlags, "R4", "hold while idle",
              CW'({flags, decData}), CW'({lastFlags, lastData}));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d1, d2;
    logic [CW-1:0] cw1, cw2, bad;
    d1 = 64'hDEAD_BEEF_0BAD_F00D;
    d2 = 64'h0123_4567_89AB_CDEF;
    cw1 = refEncode(d1);
    cw2 = refEncode(d2);

    // R12: reset state
    decValidIn = 1'b1;
    decWord = cw1;
    repeat (3) @(negedge clk);
    check(decValidOut == 1'b0, "R12", "valid in reset", CW'(decValidOut), CW'(0));
    check(decData == '0, "R12", "data in reset", CW'(decData), CW'(0));
    check({decClean, decFixed, decBad} == 3'b000, "R12", "flags in reset",
          CW'({decClean, decFixed, decBad}), CW'(0));
    decValidIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);

    // R1 R2 R3: encoder field layout
    checkEnc('0);
    checkEnc('1);
    checkEnc(d2);
    checkEnc(64'h8000_0000_0000_0000);
    checkEnc(64'h5555_AAAA_5555_AAAA);
    checkEnc(d1);

    // R5: clean words, back to back
    sendWord(cw1, d1, F_CLEAN, "R5");
    sendWord(refEncode('0), '0, F_CLEAN, "R5");
    sendWord(refEncode('1), '1, F_CLEAN, "R5");
    idle(2);

    // R6: single data errors at corners and centre
    sendWord(flip3(cw1, 0, -1, -1), d1, F_FIXED, "R6");
    sendWord(flip3(cw2, 27, -1, -1), d2, F_FIXED, "R6");
    sendWord(flip3(cw1, 63, -1, -1), d1, F_FIXED, "R6");
    idle(1);

    // R7: two data errors, disjoint lines, shared row, shared column
    sendWord(flip3(cw1, 9, 38, -1), d1, F_FIXED, "R7");
    sendWord(flip3(cw2, 17, 22, -1), d2, F_FIXED, "R7");
    sendWord(flip3(cw1, 12, 52, -1), d1, F_FIXED, "R7");
    idle(1);

    // R8: three data errors on distinct lines
    sendWord(flip3(cw2, 1, 31, 51), d2, F_FIXED, "R8");
    sendWord(flip3(cw1, 1, 31, 51), d1, F_FIXED, "R8");
    idle(1);

    // R9: check-bit-only errors
    sendWord(flip3(cw1, 70, -1, -1), d1, F_FIXED, "R9");
    sendWord(flip3(cw2, 112, -1, -1), d2, F_FIXED, "R9");
    sendWord(flip3(cw1, 75, 100, -1), d1, F_FIXED, "R9");
    sendWord(flip3(cw2, 64, 80, 113), d2, F_FIXED, "R9");
    idle(1);

    // R10: inconsistent patterns pass through untouched
    bad = flip3(cw1, 27, 67, -1);
    sendWord(bad, bad[DW-1:0], F_BAD, "R10");
    bad = flip3(cw2, 0, 110, -1);
    sendWord(bad, bad[DW-1:0], F_BAD, "R10");
    idle(3);

    // R4: a clean word after a bad one, then a long idle
    sendWord(cw2, d2, F_CLEAN, "R4");
    idle(5);

    finished = 1'b1;
    check(expQ.size() == 0, "R4", "all results delivered", CW'(expQ.size()), CW'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule